// File: doc/BRIEF.md
# Periodic Mantissa Normalizer

This block brings a number held in double-mantissa form to its simplest legal encoding. The form is a sign, an exponent, a fixed (non-repeating) digit string and a periodic digit string that repeats without end. It is placed after a double-mantissa adder. The adder's raw result may hide a short period inside a longer one, may end its fixed part with digits that already belong to the repetition, and may carry leading zeros. The normalizer removes all three without changing the value it encodes.

A start pulse captures one operand. A sequential controller then runs three phases, each taking at most one digit step per cycle. The first phase searches for the shortest period by rotate-and-compare. The second folds trailing fixed digits into the period. The third strips leading zeros from the fixed part and lowers the exponent by one per zero removed. A bypass input passes the operand through untouched, so a denormalized value can be handed on as it is. A one-cycle done pulse marks the moment the outputs hold the result; the outputs then hold it until the next operation is captured.

Top module: `pmn_normalizer`

## Requirements
- R1: Digit layout: the fixed digits are `fix[fix_len-1:0]`, bit `fix_len-1` being the first digit after the radix point and bit 0 the last fixed digit; the periodic digits are `per[per_len-1:0]` in the same order. The value is (-1)^sign · 0.f(p)(p)… · 2^exp, with exp in two's complement. When the stage is not bypassed, bits above each length are cleared on capture and the sign passes through unchanged.
- R2: Reset clears busy, done and every output field to zero.
- R3: A start while idle captures the operand and raises busy. Done is high for exactly one cycle, and busy stays high through that cycle. A start while busy is ignored.
- R4: With bypass high at start, every output field equals the corresponding input exactly, including bits above the lengths, and done is high in the cycle that follows the capturing edge.
- R5: A periodic part whose valid digits are all zero is reported as no periodic part: per_len 0, per 0.
- R6: If the period of length n equals itself rotated left by r digits, and r < n is the smallest such count, the result period is its first r digits with per_len r.
- R7: While the fixed part is non-empty and its last digit equals the last periodic digit, that fixed digit is removed and the period is rotated right by one digit.
- R8: While the fixed part contains a 1 and its first digit is 0, that digit is removed and the exponent is decreased by one. A fixed part made only of zeros is kept as it is.
- R9: The exponent is never decreased below its most negative value (8'h80 at default width); leading-zero removal stops there.
- R10: An already-legal operand is returned unchanged. One example is one hundredth: fixed "00" of length 2 with the 20-digit period 00001010001111010111 (0x0A3D7).
- R11: Done arrives no more than per_len + 2·fix_len + 4 cycles after the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture the operand when idle |
| bypass | input | 1 | Pass the operand through without normalization |
| in_sign | input | 1 | Operand sign |
| in_exp | input | EXP_W | Operand exponent, two's complement |
| in_fix | input | MF_W | Fixed digits, right-justified |
| in_fix_len | input | $clog2(MF_W+1) | Number of fixed digits |
| in_per | input | MP_W | Periodic digits, right-justified |
| in_per_len | input | $clog2(MP_W+1) | Number of periodic digits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W | Result exponent |
| out_fix | output | MF_W | Result fixed digits |
| out_fix_len | output | $clog2(MF_W+1) | Result fixed length |
| out_per | output | MP_W | Result periodic digits |
| out_per_len | output | $clog2(MP_W+1) | Result periodic length |

## Verification
The assertions check on every cycle the properties that any non-bypassed result must have. Done is a single-cycle pulse within its latency bound. The exponent only falls during an operation. A reported period is never all zeros. The last fixed digit differs from the last periodic digit. The leading fixed digit is 1 unless the fixed part is all zeros or the exponent sits at its floor. The bypass turnaround is checked as well. None of these can show that the value was kept or that the shortest period was chosen. Only the bench's directed scenarios show that, because they compare exact result digits: sub-period reduction, folding a fixed part away entirely, the exponent floor, the unchanged one-hundredth case and an ignored start.

// File: rtl/pmn_pkg.sv
// Shared types for the periodic mantissa normalizer.
// Assumes: nothing beyond the controller's phase list.
package pmn_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SUB,
        ST_FOLD,
        ST_LEAD,
        ST_DONE
    } pmn_state_t;
endpackage

// File: rtl/pmn_len_mask.sv
// Builds a mask of the low `len` bits of a W-bit digit field.
// Assumes: len may exceed W; the mask then saturates to all ones.
module pmn_len_mask #(
    parameter int W  = 32,
    parameter int LW = 6
) (
    input  logic [LW-1:0] len,
    output logic [W-1:0]  mask
);
    // Mask generation: (1 << len) - 1 computed one bit wider, then truncated.
    always_comb begin
        mask = W'(((W+1)'(1) << len) - (W+1)'(1));
    end
endmodule

// File: rtl/pmn_rotator.sv
// Rotates the low `len` digits of a field by one position.
// DIR_LEFT=1 moves the first digit to the end; DIR_LEFT=0 moves the last digit to the front.
// Assumes: bits of val above len are zero; mask is the len mask.
module pmn_rotator #(
    parameter int W        = 32,
    parameter int LW       = 6,
    parameter bit DIR_LEFT = 1'b1
) (
    input  logic [W-1:0]  val,
    input  logic [LW-1:0] len,
    input  logic [W-1:0]  mask,
    output logic [W-1:0]  rot
);
    logic [LW-1:0] wrap_amt;

    // Wrap distance: digit moves across len-1 positions.
    always_comb wrap_amt = len - LW'(1);

    generate
        if (DIR_LEFT) begin : g_left
            // Left rotation within the valid window.
            always_comb rot = ((val << 1) | (val >> wrap_amt)) & mask;
        end else begin : g_right
            // Right rotation within the valid window.
            always_comb rot = ((val >> 1) | (val << wrap_amt)) & mask;
        end
    endgenerate
endmodule

// File: rtl/pmn_lead_scan.sv
// Reports the first digit of a right-justified field and whether any digit is one.
// Assumes: bits of val above len are zero.
module pmn_lead_scan #(
    parameter int W  = 32,
    parameter int LW = 6
) (
    input  logic [W-1:0]  val,
    input  logic [LW-1:0] len,
    output logic          lead,
    output logic          any_one
);
    logic [W-1:0] pos;

    // One-hot pointer at bit len-1, zero when len is zero.
    always_comb pos = W'(((W+1)'(1) << len) >> 1);

    // Scan results.
    always_comb begin
        lead    = |(val & pos);
        any_one = |val;
    end
endmodule

// File: rtl/pmn_normalizer.sv
// Periodic mantissa normalizer: sub-period reduction, tail folding and
// leading-zero removal of a double-mantissa number, one digit step per cycle.
// Assumes: lengths do not exceed field widths; start is ignored while busy.
module pmn_normalizer
    import pmn_pkg::*;
#(
    parameter int MF_W  = 32,
    parameter int MP_W  = 32,
    parameter int EXP_W = 8,
    localparam int LF   = $clog2(MF_W + 1),
    localparam int LP   = $clog2(MP_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             bypass,
    input  logic             in_sign,
    input  logic [EXP_W-1:0] in_exp,
    input  logic [MF_W-1:0]  in_fix,
    input  logic [LF-1:0]    in_fix_len,
    input  logic [MP_W-1:0]  in_per,
    input  logic [LP-1:0]    in_per_len,
    output logic             busy,
    output logic             done,
    output logic             out_sign,
    output logic [EXP_W-1:0] out_exp,
    output logic [MF_W-1:0]  out_fix,
    output logic [LF-1:0]    out_fix_len,
    output logic [MP_W-1:0]  out_per,
    output logic [LP-1:0]    out_per_len
);
    localparam logic [EXP_W-1:0] EXP_FLOOR = {1'b1, {(EXP_W-1){1'b0}}};

    pmn_state_t       state_q;
    logic             sign_q;
    logic [EXP_W-1:0] exp_q;
    logic [MF_W-1:0]  fix_q;
    logic [LF-1:0]    fix_len_q;
    logic [MP_W-1:0]  per_q;
    logic [LP-1:0]    per_len_q;
    logic [MP_W-1:0]  rot_q;
    logic [LP-1:0]    rcnt_q;

    logic [MF_W-1:0]  in_fix_mask;
    logic [MP_W-1:0]  in_per_mask;
    logic [MP_W-1:0]  per_mask;
    logic [MP_W-1:0]  rot_next;
    logic [MP_W-1:0]  per_ror;
    logic             fix_lead;
    logic             fix_any;
    logic [LP-1:0]    rnext;
    logic             can_fold;
    logic             can_shift;

    pmn_len_mask #(.W(MF_W), .LW(LF)) u_in_fix_mask (.len(in_fix_len), .mask(in_fix_mask));
    pmn_len_mask #(.W(MP_W), .LW(LP)) u_in_per_mask (.len(in_per_len), .mask(in_per_mask));
    pmn_len_mask #(.W(MP_W), .LW(LP)) u_per_mask    (.len(per_len_q),  .mask(per_mask));

    pmn_rotator #(.W(MP_W), .LW(LP), .DIR_LEFT(1'b1)) u_rot_search (
        .val(rot_q), .len(per_len_q), .mask(per_mask), .rot(rot_next));
    pmn_rotator #(.W(MP_W), .LW(LP), .DIR_LEFT(1'b0)) u_rot_fold (
        .val(per_q), .len(per_len_q), .mask(per_mask), .rot(per_ror));

    pmn_lead_scan #(.W(MF_W), .LW(LF)) u_fix_scan (
        .val(fix_q), .len(fix_len_q), .lead(fix_lead), .any_one(fix_any));

    // Step conditions for the search, fold and shift phases.
    always_comb begin
        rnext     = rcnt_q + LP'(1);
        can_fold  = (fix_len_q != '0) && (per_len_q != '0) && (fix_q[0] == per_q[0]);
        can_shift = (fix_len_q != '0) && fix_any && !fix_lead && (exp_q != EXP_FLOOR);
    end

    // Controller and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            sign_q    <= 1'b0;
            exp_q     <= '0;
            fix_q     <= '0;
            fix_len_q <= '0;
            per_q     <= '0;
            per_len_q <= '0;
            rot_q     <= '0;
            rcnt_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        sign_q <= in_sign;
                        exp_q  <= in_exp;
                        rcnt_q <= '0;
                        if (bypass) begin
                            fix_q     <= in_fix;
                            fix_len_q <= in_fix_len;
                            per_q     <= in_per;
                            per_len_q <= in_per_len;
                            rot_q     <= '0;
                            state_q   <= ST_DONE;
                        end else begin
                            fix_q     <= in_fix & in_fix_mask;
                            fix_len_q <= in_fix_len;
                            per_q     <= in_per & in_per_mask;
                            rot_q     <= in_per & in_per_mask;
                            per_len_q <= (|(in_per & in_per_mask)) ? in_per_len : '0;
                            state_q   <= ST_SUB;
                        end
                    end
                end
                ST_SUB: begin
                    if (per_len_q <= LP'(1) || rnext == per_len_q) begin
                        state_q <= ST_FOLD;
                    end else if (rot_next == per_q) begin
                        per_q     <= per_q >> (per_len_q - rnext);
                        per_len_q <= rnext;
                        state_q   <= ST_FOLD;
                    end else begin
                        rot_q  <= rot_next;
                        rcnt_q <= rnext;
                    end
                end
                ST_FOLD: begin
                    if (can_fold) begin
                        fix_q     <= fix_q >> 1;
                        fix_len_q <= fix_len_q - LF'(1);
                        per_q     <= per_ror;
                    end else begin
                        state_q <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (can_shift) begin
                        fix_len_q <= fix_len_q - LF'(1);
                        exp_q     <= exp_q - EXP_W'(1);
                    end else begin
                        state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output drive from the working registers.
    always_comb begin
        busy        = (state_q != ST_IDLE);
        done        = (state_q == ST_DONE);
        out_sign    = sign_q;
        out_exp     = exp_q;
        out_fix     = fix_q;
        out_fix_len = fix_len_q;
        out_per     = per_q;
        out_per_len = per_len_q;
    end
endmodule

// File: rtl/pmn_normalizer_chk.sv
// Property checker for pmn_normalizer, attached by bind.
// Assumes: observes ports only; tracks bypass and a latency budget per operation.
module pmn_normalizer_chk #(
    parameter int MF_W  = 32,
    parameter int MP_W  = 32,
    parameter int EXP_W = 8,
    localparam int LF   = $clog2(MF_W + 1),
    localparam int LP   = $clog2(MP_W + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             bypass,
    input logic [LF-1:0]    in_fix_len,
    input logic [LP-1:0]    in_per_len,
    input logic             busy,
    input logic             done,
    input logic [EXP_W-1:0] out_exp,
    input logic [MF_W-1:0]  out_fix,
    input logic [LF-1:0]    out_fix_len,
    input logic [MP_W-1:0]  out_per,
    input logic [LP-1:0]    out_per_len
);
    localparam logic [EXP_W-1:0] EXP_FLOOR = {1'b1, {(EXP_W-1){1'b0}}};

    logic        byp_q;
    logic [15:0] bound_q;
    logic [15:0] cnt_q;
    logic [MF_W-1:0] lead_pos;
    logic        lead_bit;

    // Per-operation bookkeeping: bypass flag, latency budget and elapsed cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_q   <= 1'b0;
            bound_q <= '0;
            cnt_q   <= '0;
        end else if (start && !busy) begin
            byp_q   <= bypass;
            bound_q <= 16'(in_per_len) + 16'(2 * in_fix_len) + 16'd4;
            cnt_q   <= '0;
        end else if (busy && cnt_q != 16'hFFFF) begin
            cnt_q <= cnt_q + 16'd1;
        end
    end

    // First fixed digit of the result.
    always_comb begin
        lead_pos = MF_W'(((MF_W+1)'(1) << out_fix_len) >> 1);
        lead_bit = |(out_fix & lead_pos);
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R3
    AST_BYPASS_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && bypass) |=> done); // R4
    AST_NONZERO_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !byp_q && out_per_len != '0) |-> (|out_per)); // R5
    AST_TAIL_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !byp_q && out_fix_len != '0 && out_per_len != '0) |-> (out_fix[0] != out_per[0])); // R7
    AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !byp_q && out_fix_len != '0 && (|out_fix) && out_exp != EXP_FLOOR) |-> lead_bit); // R8
    AST_EXP_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($signed(out_exp) <= $signed($past(out_exp)))); // R9
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_q < bound_q)); // R11
endmodule

bind pmn_normalizer pmn_normalizer_chk #(
    .MF_W(MF_W), .MP_W(MP_W), .EXP_W(EXP_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .bypass(bypass),
    .in_fix_len(in_fix_len), .in_per_len(in_per_len),
    .busy(busy), .done(done), .out_exp(out_exp),
    .out_fix(out_fix), .out_fix_len(out_fix_len),
    .out_per(out_per), .out_per_len(out_per_len)
);

// File: tb/pmn_normalizer_tb_top.sv
// Directed bench for pmn_normalizer: one task per scenario, each checking its results.
module pmn_normalizer_tb_top;
    localparam int MF_W  = 32;
    localparam int MP_W  = 32;
    localparam int EXP_W = 8;
    localparam int LF    = $clog2(MF_W + 1);
    localparam int LP    = $clog2(MP_W + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             bypass = 1'b0;
    logic             in_sign = 1'b0;
    logic [EXP_W-1:0] in_exp = '0;
    logic [MF_W-1:0]  in_fix = '0;
    logic [LF-1:0]    in_fix_len = '0;
    logic [MP_W-1:0]  in_per = '0;
    logic [LP-1:0]    in_per_len = '0;
    logic             busy, done, out_sign;
    logic [EXP_W-1:0] out_exp;
    logic [MF_W-1:0]  out_fix;
    logic [LF-1:0]    out_fix_len;
    logic [MP_W-1:0]  out_per;
    logic [LP-1:0]    out_per_len;

    int checks = 0;
    int errors = 0;
    int lat = 0;

    always #5 clk = ~clk;

    pmn_normalizer dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .bypass(bypass),
        .in_sign(in_sign), .in_exp(in_exp), .in_fix(in_fix), .in_fix_len(in_fix_len),
        .in_per(in_per), .in_per_len(in_per_len), .busy(busy), .done(done),
        .out_sign(out_sign), .out_exp(out_exp), .out_fix(out_fix),
        .out_fix_len(out_fix_len), .out_per(out_per), .out_per_len(out_per_len)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Drive one operand, pulse start, wait for done; lat = cycles after capture.
    task automatic run_op(input logic byp, input logic s, input logic [EXP_W-1:0] e,
                          input logic [MF_W-1:0] f, input logic [LF-1:0] fl,
                          input logic [MP_W-1:0] p, input logic [LP-1:0] pl);
        @(negedge clk);
        bypass = byp; in_sign = s; in_exp = e; in_fix = f; in_fix_len = fl;
        in_per = p; in_per_len = pl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 500) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic expect_out(input string tag, input logic s, input logic [EXP_W-1:0] e,
                              input logic [MF_W-1:0] f, input logic [LF-1:0] fl,
                              input logic [MP_W-1:0] p, input logic [LP-1:0] pl);
        chk({tag, " done"}, 64'(done), 64'd1);
        chk({tag, " sign"}, 64'(out_sign), 64'(s));
        chk({tag, " exp"}, 64'(out_exp), 64'(e));
        chk({tag, " fix"}, 64'(out_fix), 64'(f));
        chk({tag, " fix_len"}, 64'(out_fix_len), 64'(fl));
        chk({tag, " per"}, 64'(out_per), 64'(p));
        chk({tag, " per_len"}, 64'(out_per_len), 64'(pl));
    endtask

    task automatic t_reset();
        chk("R2 busy", 64'(busy), 64'd0);
        chk("R2 done", 64'(done), 64'd0);
        chk("R2 fields", 64'(out_fix) | 64'(out_per) | 64'(out_exp) | 64'(out_fix_len), 64'd0);
    endtask

    task automatic t_hundredth();
        run_op(1'b0, 1'b0, 8'd0, 32'h0, 6'd2, 32'h0A3D7, 6'd20);
        expect_out("R10 one-hundredth", 1'b0, 8'd0, 32'h0, 6'd2, 32'h0A3D7, 6'd20);
        chk("R11 latency bound", 64'(lat <= 20 + 4 + 4), 64'd1);
    endtask

    task automatic t_subperiod();
        run_op(1'b0, 1'b1, 8'd4, 32'h0, 6'd0, 32'b101010, 6'd6);
        expect_out("R6 period 101010", 1'b1, 8'd4, 32'h0, 6'd0, 32'b10, 6'd2);
        run_op(1'b0, 1'b0, 8'd4, 32'h0, 6'd0, 32'b011011, 6'd6);
        expect_out("R6 period 011011", 1'b0, 8'd4, 32'h0, 6'd0, 32'b011, 6'd3);
    endtask

    task automatic t_fold();
        run_op(1'b0, 1'b0, 8'd1, 32'b1011, 6'd4, 32'b01, 6'd2);
        expect_out("R7 fold one digit", 1'b0, 8'd1, 32'b101, 6'd3, 32'b10, 6'd2);
        run_op(1'b0, 1'b0, 8'd1, 32'b11, 6'd2, 32'b1, 6'd1);
        expect_out("R7 fold to empty", 1'b0, 8'd1, 32'h0, 6'd0, 32'b1, 6'd1);
    endtask

    task automatic t_zero_period();
        run_op(1'b0, 1'b0, 8'd3, 32'b0110, 6'd4, 32'h0, 6'd5);
        expect_out("R5 zero period", 1'b0, 8'd2, 32'b110, 6'd3, 32'h0, 6'd0);
    endtask

    task automatic t_lead();
        run_op(1'b0, 1'b0, 8'd5, 32'b0011, 6'd4, 32'b10, 6'd2);
        expect_out("R8 two leading zeros", 1'b0, 8'd3, 32'b11, 6'd2, 32'b10, 6'd2);
        run_op(1'b0, 1'b0, 8'd0, 32'b0110, 6'd4, 32'b101010, 6'd6);
        expect_out("R8 all phases", 1'b0, 8'hFF, 32'b1, 6'd1, 32'b10, 6'd2);
    endtask

    task automatic t_floor();
        run_op(1'b0, 1'b0, 8'h80, 32'b001, 6'd3, 32'h0, 6'd0);
        expect_out("R9 at floor", 1'b0, 8'h80, 32'b001, 6'd3, 32'h0, 6'd0);
        run_op(1'b0, 1'b0, 8'h81, 32'b001, 6'd3, 32'h0, 6'd0);
        expect_out("R9 reach floor", 1'b0, 8'h80, 32'b01, 6'd2, 32'h0, 6'd0);
    endtask

    task automatic t_mask();
        run_op(1'b0, 1'b1, 8'd7, 32'hF000_0005, 6'd3, 32'hFF00_0002, 6'd2);
        expect_out("R1 masking", 1'b1, 8'd7, 32'h5, 6'd3, 32'h2, 6'd2);
    endtask

    task automatic t_bypass();
        run_op(1'b1, 1'b1, 8'h90, 32'hF000_0001, 6'd3, 32'h0000_002A, 6'd6);
        chk("R4 bypass turnaround", 64'(lat), 64'd1);
        expect_out("R4 bypass", 1'b1, 8'h90, 32'hF000_0001, 6'd3, 32'h2A, 6'd6);
    endtask

    task automatic t_busy_ignore();
        @(negedge clk);
        bypass = 1'b0; in_sign = 1'b0; in_exp = 8'd0; in_fix = 32'h0; in_fix_len = 6'd2;
        in_per = 32'h0A3D7; in_per_len = 6'd20; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R3 busy after start", 64'(busy), 64'd1);
        repeat (3) @(negedge clk);
        in_exp = 8'd9; in_fix = 32'b1; in_fix_len = 6'd1; in_per = 32'b1; in_per_len = 6'd1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 500) begin
            @(negedge clk);
            lat++;
        end
        expect_out("R3 start ignored", 1'b0, 8'd0, 32'h0, 6'd2, 32'h0A3D7, 6'd20);
        @(negedge clk);
        chk("R3 done one cycle", 64'(done), 64'd0);
        chk("R3 idle after done", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hundredth();
        t_subperiod();
        t_fold();
        t_zero_period();
        t_lead();
        t_floor();
        t_mask();
        t_bypass();
        t_busy_ignore();
        finish_run();
    end
endmodule